// File: doc/BRIEF.md
# Toggle-Cleared Watchdog Supervisor

This block supervises a host processor through one input line. The host shows it is alive by toggling that line. Each qualifying edge restarts an internal timeout counter. If no edge arrives before the selected timeout ends, the block pulls its active-low alert output low. System logic uses that alert to restart the host. Timeouts, pulse widths and the deglitch length are all set in nanoseconds, and the block converts them to clock cycles from a clock-frequency parameter.

The watch line and the enable line each pass through a two-flop synchronizer and then a deglitch filter. One parameter sets whether only rising edges count as activity or both edges count. A second parameter selects the alert pulse shape:

- **Fixed pulse:** a pulse of fixed width that ignores the watch line.
- **Variable pulse:** a pulse that holds for a minimum width and then ends on the first activity. If no activity arrives, it ends after one full timeout.

The enable input is active low. A high level stops supervision and holds the alert high. A high-to-low return on the enable input restarts the count. If the watch line is stuck and supervision is enabled, the alert cycles without end: it is high for one timeout and then low for one pulse.

Top module: `wdt_toggle_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wdo_n` is 1. Counting starts from zero when reset is released.
- R2: `tsel` picks the timeout: 0 selects TWD0, 1 selects TWD1, 2 selects TWD2 and 3 selects TWD3. The defaults are 3.4 ms, 6.3 ms, 102 ms and 1.6 s. With a stuck input, `wdo_n` falls exactly TWD cycles after reset release.
- R3: A filtered low-to-high transition of `wdi` restarts the timeout. Toggling faster than the timeout keeps `wdo_n` high.
- R4: A filtered high-to-low transition of `wdi` restarts the timeout only when BOTH_EDGES=1.
- R5: A `wdi` pulse shorter than the deglitch length (GLITCH_NS, 500 ns by default) has no effect. A pulse of 1 µs or longer is accepted.
- R6: With FIXED_PULSE=1, the alert lasts exactly TPW cycles, and `wdi` transitions during the pulse are ignored.
- R7: With FIXED_PULSE=0, the alert ends on the first qualifying `wdi` edge that occurs after the minimum width. With no such edge, it ends after one timeout period.
- R8: When `en_n` is high, supervision stops and `wdo_n` stays 1.
- R9: A filtered high-to-low return of `en_n`, after a high period of at least the deglitch length, restarts the timeout from zero.
- R10: With a stuck input and `en_n` low, the output cycles: it is low for one pulse and then high for exactly one timeout, because each output transition clears the counter.
- R11: Once raised, the alert stays low for at least the minimum width (MINPW_NS, 10 µs by default), even if `en_n` goes high during it. A disable that is already in effect releases the alert once the minimum width is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wdi | input | 1 | Watch line toggled by the host |
| en_n | input | 1 | Active-low enable; high disables supervision |
| tsel | input | 2 | Timeout select |
| wdo_n | output | 1 | Active-low alert |

## Verification
The hardest situations to reach involve enable or input activity that falls inside the alert's minimum-width window. In those cases the edge must be swallowed and not act, and that is invisible unless pulse lengths are timed. The bench counts cycles from reset release and raises the enable, or toggles the watch line, a fixed number of cycles after the measured fall of the alert. These moments are placed inside the minimum window, after allowing for the synchronizer and filter delay. The bench then checks the exact cycle at which the alert rises again.

// File: rtl/wdt_toggle_supervisor.sv
module wdt_toggle_supervisor #(
  parameter int unsigned     CLK_HZ      = 10_000_000,
  parameter longint unsigned TWD0_NS     = 3_400_000,
  parameter longint unsigned TWD1_NS     = 6_300_000,
  parameter longint unsigned TWD2_NS     = 102_000_000,
  parameter longint unsigned TWD3_NS     = 1_600_000_000,
  parameter longint unsigned TPW_NS      = 210_000_000,
  parameter longint unsigned MINPW_NS    = 10_000,
  parameter longint unsigned GLITCH_NS   = 500,
  parameter bit              BOTH_EDGES  = 1'b0,
  parameter bit              FIXED_PULSE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdi,
  input  logic       en_n,
  input  logic [1:0] tsel,
  output logic       wdo_n
);

  function automatic longint unsigned ns2cyc(longint unsigned ns);
    longint unsigned c;
    c = (ns * longint'(CLK_HZ)) / 64'd1_000_000_000;
    return (c < 2) ? 64'd2 : c;
  endfunction

  function automatic longint unsigned max2(longint unsigned a, longint unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam longint unsigned TWD0_C = ns2cyc(TWD0_NS);
  localparam longint unsigned TWD1_C = ns2cyc(TWD1_NS);
  localparam longint unsigned TWD2_C = ns2cyc(TWD2_NS);
  localparam longint unsigned TWD3_C = ns2cyc(TWD3_NS);
  localparam longint unsigned TPW_C  = ns2cyc(TPW_NS);
  localparam longint unsigned MIN_C  = ns2cyc(MINPW_NS);
  localparam longint unsigned GL_C   = ns2cyc(GLITCH_NS);
  localparam longint unsigned MAX_C  =
    max2(max2(max2(TWD0_C, TWD1_C), max2(TWD2_C, TWD3_C)), max2(TPW_C, MIN_C));
  localparam int CW = $clog2(MAX_C + 1);
  localparam int GW = $clog2(GL_C + 1);
  localparam int NCH = 2;

  localparam logic [CW-1:0] TPW_LAST = CW'(TPW_C - 1);
  localparam logic [CW-1:0] MIN_LAST = CW'(MIN_C - 1);
  localparam logic [GW-1:0] GL_LAST  = GW'(GL_C - 1);

  logic [NCH-1:0] raw, filt, upd;
  assign raw = {en_n, wdi};

  for (genvar i = 0; i < NCH; i++) begin : g_flt
    logic s1, s2, f;
    logic [GW-1:0] gc;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
        f  <= 1'b0;
        gc <= '0;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
        if (s2 == f) begin
          gc <= '0;
        end else if (gc == GL_LAST) begin
          f  <= s2;
          gc <= '0;
        end else begin
          gc <= gc + 1'b1;
        end
      end
    end
    assign filt[i] = f;
    assign upd[i]  = (s2 != f) && (gc == GL_LAST);
  end

  logic wdi_rise, wdi_fall, en_ret, dis, act;
  assign wdi_rise = upd[0] & ~filt[0];
  assign wdi_fall = upd[0] &  filt[0];
  assign en_ret   = upd[1] &  filt[1];
  assign dis      = filt[1];
  assign act      = wdi_rise | (BOTH_EDGES & wdi_fall);

  logic [CW-1:0] twd_cyc;
  always_comb begin
    case (tsel)
      2'd0:    twd_cyc = CW'(TWD0_C);
      2'd1:    twd_cyc = CW'(TWD1_C);
      2'd2:    twd_cyc = CW'(TWD2_C);
      default: twd_cyc = CW'(TWD3_C);
    endcase
  end

  logic          alert;
  logic [CW-1:0] cnt;
  logic          min_met, rel, expire;

  assign min_met = (cnt >= MIN_LAST);
  assign expire  = (cnt >= twd_cyc - 1'b1);

  if (FIXED_PULSE) begin : g_fixed
    assign rel = (cnt >= TPW_LAST) | (min_met & dis);
  end else begin : g_var
    assign rel = min_met & (act | dis | expire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alert <= 1'b0;
      cnt   <= '0;
    end else if (alert) begin
      if (rel) begin
        alert <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (dis || act || en_ret) begin
      cnt <= '0;
    end else if (expire) begin
      alert <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign wdo_n = ~alert;

endmodule

// File: rtl/wdt_toggle_supervisor_chk.sv
module wdt_toggle_supervisor_chk #(
  parameter int CW      = 8,
  parameter bit FIXED   = 1'b1,
  parameter int MIN_CYC = 2,
  parameter int TPW_CYC = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          wdo_n,
  input logic          en_f,
  input logic [CW-1:0] twd_cyc
);

  int unsigned lowrun;
  always_ff @(posedge clk) begin
    if (rst || wdo_n) lowrun <= 0;
    else              lowrun <= lowrun + 1;
  end

  p_reset_high_r1: assert property (@(posedge clk) rst |=> wdo_n);

  p_disabled_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (en_f && wdo_n) |=> wdo_n);

  p_min_width_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(wdo_n) |-> lowrun >= MIN_CYC);

  if (FIXED) begin : g_fix
    p_fixed_width_r6: assert property (@(posedge clk) disable iff (rst)
      ($rose(wdo_n) && !$past(en_f)) |-> lowrun == TPW_CYC);
  end else begin : g_var
    p_var_max_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(wdo_n) |-> lowrun <= twd_cyc);
  end

endmodule

bind wdt_toggle_supervisor wdt_toggle_supervisor_chk #(
  .CW(CW), .FIXED(FIXED_PULSE), .MIN_CYC(int'(MIN_C)), .TPW_CYC(int'(TPW_C))
) u_chk (
  .clk(clk), .rst(rst), .wdo_n(wdo_n), .en_f(filt[1]), .twd_cyc(twd_cyc)
);

// File: tb/wdt_toggle_supervisor_test.sv
module wdt_toggle_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int TWD0 = 2000, TWD1 = 3000, TPW = 500, MINW = 100;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1;
  logic wdi_a = 0, en_a = 0, wdi_b = 0, en_b = 0;
  logic [1:0] tsel = 2'd0;
  logic wdo_a, wdo_b;

  wdt_toggle_supervisor #(
    .CLK_HZ(100_000_000), .TWD0_NS(20_000), .TWD1_NS(30_000), .TWD2_NS(40_000),
    .TWD3_NS(50_000), .TPW_NS(5_000), .MINPW_NS(1_000), .GLITCH_NS(300),
    .BOTH_EDGES(1'b0), .FIXED_PULSE(1'b1)
  ) uut (.clk(clk), .rst(rst), .wdi(wdi_a), .en_n(en_a), .tsel(tsel), .wdo_n(wdo_a));

  wdt_toggle_supervisor #(
    .CLK_HZ(100_000_000), .TWD0_NS(20_000), .TWD1_NS(30_000), .TWD2_NS(40_000),
    .TWD3_NS(50_000), .TPW_NS(5_000), .MINPW_NS(1_000), .GLITCH_NS(300),
    .BOTH_EDGES(1'b1), .FIXED_PULSE(1'b0)
  ) uut_v (.clk(clk), .rst(rst), .wdi(wdi_b), .en_n(en_b), .tsel(tsel), .wdo_n(wdo_b));

  int checks = 0, errors = 0, cyc = 0;
  int fall1[2], fall2[2], rise1[2], lows[2];
  logic prev[2];

  function automatic logic outv(int i);
    return (i == 0) ? wdo_a : wdo_b;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 2; i++) begin
      logic v;
      v = outv(i);
      if (!v) lows[i]++;
      if (prev[i] && !v) begin
        if (fall1[i] < 0) fall1[i] = cyc;
        else if (fall2[i] < 0) fall2[i] = cyc;
      end
      if (!prev[i] && v && rise1[i] < 0 && fall1[i] >= 0) rise1[i] = cyc;
      prev[i] = v;
    end
  endtask

  task automatic do_reset(logic ea, logic eb);
    @(negedge clk);
    rst = 1; wdi_a = 0; wdi_b = 0; en_a = ea; en_b = eb;
    repeat (4) @(negedge clk);
    chk(wdo_a && wdo_b, "R1 reset level", {wdo_a, wdo_b}, 3);
    rst = 0;
    cyc = 0;
    for (int i = 0; i < 2; i++) begin
      fall1[i] = -1; fall2[i] = -1; rise1[i] = -1; lows[i] = 0; prev[i] = 1'b1;
    end
  endtask

  task automatic t_timeout_cycle();
    tsel = 2'd0;
    do_reset(0, 0);
    while (cyc < 5000) step();
    chk(fall1[0] == TWD0, "R2 timeout sel0", fall1[0], TWD0);
    chk(rise1[0] - fall1[0] == TPW, "R6 fixed width", rise1[0] - fall1[0], TPW);
    chk(fall2[0] - rise1[0] == TWD0, "R10 stuck period", fall2[0] - rise1[0], TWD0);
    chk(rise1[1] - fall1[1] == TWD0, "R7 var max width", rise1[1] - fall1[1], TWD0);
    tsel = 2'd1;
    do_reset(0, 0);
    while (cyc < 3100) step();
    chk(fall1[0] == TWD1, "R2 timeout sel1", fall1[0], TWD1);
    tsel = 2'd0;
  endtask

  task automatic t_kick();
    do_reset(0, 0);
    while (cyc < 12000) begin
      step();
      if (cyc % 600 == 0) begin wdi_a = ~wdi_a; wdi_b = ~wdi_b; end
    end
    chk(lows[0] == 0, "R3 kick keeps high", lows[0], 0);
    chk(lows[1] == 0, "R3 kick keeps high var", lows[1], 0);
  endtask

  task automatic t_fall_edge();
    do_reset(0, 0);
    while (cyc < 3600) begin
      step();
      if (cyc == 100)  begin wdi_a = 1; wdi_b = 1; end
      if (cyc == 1300) begin wdi_a = 0; wdi_b = 0; end
      if (cyc == 2400) begin
        chk(!wdo_a, "R4 rising-only ignores fall", wdo_a, 0);
        chk(wdo_b, "R4 both-edge fall clears", wdo_b, 1);
      end
    end
    chk(!wdo_b, "R4 both-edge later timeout", wdo_b, 0);
  endtask

  task automatic t_glitch();
    do_reset(0, 0);
    while (cyc < 2100) begin
      step();
      wdi_a = (cyc % 200) < 5;
      wdi_b = wdi_a;
    end
    wdi_a = 0; wdi_b = 0;
    chk(fall1[0] == TWD0, "R5 glitches ignored", fall1[0], TWD0);
    chk(fall1[1] == TWD0, "R5 glitches ignored var", fall1[1], TWD0);
  endtask

  task automatic t_fixed_ignore();
    do_reset(0, 0);
    while (cyc < TWD0 + TPW + 50) begin
      step();
      if (cyc > TWD0 && cyc < TWD0 + TPW - 100 && (cyc - TWD0) % 100 == 0) wdi_a = ~wdi_a;
    end
    chk(rise1[0] - fall1[0] == TPW, "R6 input ignored in pulse", rise1[0] - fall1[0], TPW);
  endtask

  task automatic t_var_release();
    do_reset(0, 0);
    while (cyc < TWD0 + 600) begin
      step();
      if (cyc == TWD0 + 40)  wdi_b = 1;
      if (cyc == TWD0 + 300) wdi_b = 0;
    end
    chk(rise1[1] - fall1[1] > 300 && rise1[1] - fall1[1] < 350,
        "R7 release on activity", rise1[1] - fall1[1], 333);
  endtask

  task automatic t_disable();
    do_reset(1, 1);
    while (cyc < 5000) step();
    chk(lows[0] == 0 && lows[1] == 0, "R8 disabled holds high", lows[0] + lows[1], 0);
  endtask

  task automatic t_enable_pulse();
    do_reset(0, 0);
    while (cyc < 3800) begin
      step();
      if (cyc == 1500) en_a = 1;
      if (cyc == 1600) en_a = 0;
      if (cyc == 2200) chk(wdo_a, "R9 enable pulse restarts", wdo_a, 1);
    end
    chk(!wdo_a, "R9 timeout after restart", wdo_a, 0);
  endtask

  task automatic t_min_hold();
    do_reset(0, 0);
    while (cyc < TWD0 + 3000) begin
      step();
      if (cyc == TWD0 + 20) begin en_a = 1; en_b = 1; end
    end
    chk(rise1[0] - fall1[0] == MINW, "R11 min width fixed", rise1[0] - fall1[0], MINW);
    chk(rise1[1] - fall1[1] == MINW, "R11 min width var", rise1[1] - fall1[1], MINW);
    chk(fall2[0] < 0 && fall2[1] < 0, "R8 stays high after release", fall2[0], -1);
    en_a = 0; en_b = 0;
  endtask

  initial begin
    t_timeout_cycle();
    t_kick();
    t_fall_edge();
    t_glitch();
    t_fixed_ignore();
    t_var_release();
    t_disable();
    t_enable_pulse();
    t_min_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190_000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule